// File: doc/BRIEF.md
# Receive Destination Address Hash Tap

This block sits beside a receive byte stream and watches the opening bytes of every frame. A start-of-packet strobe marks the first byte, and a per-byte valid signal marks which cycles carry data. The block runs a CRC-32 over the six destination-address bytes only, then freezes the register. The top nine bits of the frozen register are presented as a hash that the host can use to index a filter table.

Alongside the hash, the block classifies the destination address. A broadcast flag is set when every address byte is all ones, and a multicast flag follows the group bit of the first address byte. A one-cycle strobe, asserted combinationally while the seventh valid byte of the frame is on the input, tells the host that the hash and both flags are settled and can be sampled. The host then uses them to accept or reject the frame.

Top module: `rx_da_hash_tap`

## Requirements
- R1: While reset is held and right after it, `hash_o` is 9'h1FF, `bcast_o` and `mcast_o` are 0, and `byte7_o` is 0.
- R2: From the cycle after the sixth valid byte of a frame, `hash_o` equals bits [31:23] of a CRC-32 register. The register is preset to all ones at start-of-packet and then processes the six address bytes, each bit LSB first, with the reflected polynomial 32'hEDB88320 (the bit-reversed form of 32'h04C11DB7). No final inversion is applied.
- R3: After the sixth address byte, `hash_o`, `bcast_o` and `mcast_o` hold their values through all later bytes and idle cycles, until the next accepted start-of-packet.
- R4: `byte7_o` is high, in the same cycle, exactly while the seventh valid byte of a frame is on the input (the start-of-packet byte counts as byte 1). It lasts one cycle and is low for byte 8 and beyond.
- R5: `bcast_o` is 1 after the sixth address byte exactly when all six address bytes are 8'hFF.
- R6: `mcast_o` equals bit 0 of the first address byte, from the cycle after that byte.
- R7: A cycle with `dvalid_i` low is not counted and changes no output. This includes a cycle with `sop_i` high and `dvalid_i` low.
- R8: A start-of-packet with `dvalid_i` high always restarts the byte count and the CRC, including in the middle of an address. `byte7_o` is never high in a cycle that carries a start-of-packet.
- R9: No `byte7_o` pulse occurs after reset until a start-of-packet has been accepted, however many valid bytes arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sop_i | input | 1 | Marks the first byte of a frame (taken only with `dvalid_i`) |
| dvalid_i | input | 1 | The byte on `data_i` is valid this cycle |
| data_i | input | 8 | Received byte |
| hash_o | output | 9 | Top nine bits of the address CRC |
| bcast_o | output | 1 | Destination address is broadcast |
| mcast_o | output | 1 | Destination address has the group bit set |
| byte7_o | output | 1 | One-cycle strobe on the seventh valid byte |

## Verification
The embedded assertions check the following on every cycle: the strobe never lasts two cycles, and the hash is unchanged in the cycle after the strobe. Cycles with no valid data leave the hash and both flags untouched, an accepted start-of-packet resets the byte count to one, and broadcast always implies multicast at the strobe. Only the bench scenarios can show that the hash value matches the CRC of the address bytes, that the strobe falls on exactly the seventh valid byte when idle gaps and ignored start strobes are interleaved, and that a restart in mid-address or at the seventh position produces no stray strobe.

// File: rtl/rx_tap_pkg.sv
package rx_tap_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 32;

  // One byte through a reflected CRC, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_step_byte(
    input logic [CRC_W-1:0]  state,
    input logic [BYTE_W-1:0] din,
    input logic [CRC_W-1:0]  poly_rev
  );
    logic [CRC_W-1:0] s;
    logic             fb;
    s = state;
    for (int b = 0; b < BYTE_W; b++) begin
      fb = s[0] ^ din[b];
      s  = s >> 1;
      if (fb) s = s ^ poly_rev;
    end
    return s;
  endfunction

endpackage

// File: rtl/rx_tap_count.sv
module rx_tap_count #(
  parameter int unsigned DA_BYTES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sop_i,
  input  logic dvalid_i,
  output logic start_o,
  output logic cont_o,
  output logic strobe_o
);

  localparam int unsigned CW   = $clog2(DA_BYTES + 2);
  localparam logic [CW-1:0] IDLE = CW'(DA_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(DA_BYTES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    start_o  = sop_i & dvalid_i;
    cont_o   = dvalid_i & ~sop_i & (cnt_q < LAST);
    strobe_o = dvalid_i & ~sop_i & (cnt_q == LAST);
    cnt_en   = start_o | (dvalid_i & (cnt_q <= LAST));
    cnt_d    = start_o ? ONE : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= IDLE;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R8
  restart_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (cnt_q == ONE));

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= IDLE));

endmodule

// File: rtl/rx_tap_crc.sv
module rx_tap_crc
  import rx_tap_pkg::*;
#(
  parameter int unsigned      HASH_W   = 9,
  parameter logic [CRC_W-1:0] POLY_REV = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [HASH_W-1:0] hash_o
);

  localparam logic [CRC_W-1:0] PRESET = '1;

  logic [CRC_W-1:0] crc_q, crc_d, crc_base;
  logic             crc_en;

  always_comb begin
    crc_base = start_i ? PRESET : crc_q;
    crc_en   = start_i | upd_i;
    crc_d    = crc_step_byte(crc_base, data_i, POLY_REV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= PRESET;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign hash_o = crc_q[CRC_W-1 -: HASH_W];

  // R3
  crc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i || upd_i) |=> $stable(crc_q));

endmodule

// File: rtl/rx_tap_class.sv
module rx_tap_class
  import rx_tap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              bcast_o,
  output logic              mcast_o
);

  logic bc_q, bc_d, mc_q, mc_d;
  logic all_ones;

  always_comb begin
    all_ones = &data_i;
    bc_d     = bc_q;
    mc_d     = mc_q;
    if (start_i) begin
      bc_d = all_ones;
      mc_d = data_i[0];
    end else if (upd_i) begin
      bc_d = bc_q & all_ones;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q <= 1'b0;
      mc_q <= 1'b0;
    end else if (start_i || upd_i) begin
      bc_q <= bc_d;
      mc_q <= mc_d;
    end
  end

  assign bcast_o = bc_q;
  assign mcast_o = mc_q;

  // R6
  mcast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(mc_q));

endmodule

// File: rtl/rx_da_hash_tap.sv
module rx_da_hash_tap
  import rx_tap_pkg::*;
#(
  parameter int unsigned      DA_BYTES = 6,
  parameter int unsigned      HASH_W   = 9,
  parameter logic [CRC_W-1:0] POLY_REV = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_i,
  input  logic              dvalid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [HASH_W-1:0] hash_o,
  output logic              bcast_o,
  output logic              mcast_o,
  output logic              byte7_o
);

  logic start_w, cont_w, strobe_w;

  rx_tap_count #(.DA_BYTES(DA_BYTES)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .sop_i    (sop_i),
    .dvalid_i (dvalid_i),
    .start_o  (start_w),
    .cont_o   (cont_w),
    .strobe_o (strobe_w)
  );

  rx_tap_crc #(.HASH_W(HASH_W), .POLY_REV(POLY_REV)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_w),
    .upd_i   (cont_w),
    .data_i  (data_i),
    .hash_o  (hash_o)
  );

  rx_tap_class u_class (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_w),
    .upd_i   (cont_w),
    .data_i  (data_i),
    .bcast_o (bcast_o),
    .mcast_o (mcast_o)
  );

  assign byte7_o = strobe_w;

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte7_o |=> !byte7_o);

  // R3
  hash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte7_o |=> $stable(hash_o));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dvalid_i |=> ($stable(hash_o) && $stable(bcast_o) && $stable(mcast_o)));

  // R5
  bcast_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte7_o && bcast_o) |-> mcast_o);

  // R8
  no_strobe_on_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sop_i |-> !byte7_o);

endmodule

// File: tb/tb_rx_da_hash_tap.sv
module tb_rx_da_hash_tap;

  logic       clk;
  logic       rst_n;
  logic       sop_i;
  logic       dvalid_i;
  logic [7:0] data_i;
  logic [8:0] hash_o;
  logic       bcast_o;
  logic       mcast_o;
  logic       byte7_o;

  rx_da_hash_tap dut (
    .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .dvalid_i(dvalid_i),
    .data_i(data_i), .hash_o(hash_o), .bcast_o(bcast_o),
    .mcast_o(mcast_o), .byte7_o(byte7_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [8:0] h;
    logic       bc;
    logic       mc;
  } exp_t;

  exp_t       q[$];
  exp_t       last_exp;
  int         checks = 0;
  int         errors = 0;
  logic       exp_b7 = 1'b0;
  logic [7:0] fb [0:15];
  bit         done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input int n);
    logic [31:0] r;
    exp_t e;
    r = 32'hFFFF_FFFF;
    e.bc = 1'b1;
    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (r[0] != fb[k][b]) r = (r >> 1) ^ 32'hEDB88320;
        else                  r = r >> 1;
      end
      if (fb[k] != 8'hFF) e.bc = 1'b0;
    end
    e.h  = r[31:23];
    e.mc = fb[0][0];
    if (n < 6) e = '0;
    return e;
  endfunction

  task automatic idle(input int k);
    for (int c = 0; c < k; c++) begin
      @(posedge clk); #1;
      sop_i = 1'b0; dvalid_i = 1'b0; data_i = 8'h3C; exp_b7 = 1'b0;
    end
  endtask

  // Driver: presents a frame from fb[], pushes the expected strobe result.
  task automatic send_frame(input int n, input int gap_every);
    if (n >= 6) last_exp = model(n);
    if (n >= 7) q.push_back(last_exp);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sop_i = (i == 0); dvalid_i = 1'b1; data_i = fb[i]; exp_b7 = (i == 6);
      if (gap_every != 0 && (i % gap_every) == gap_every - 1) begin
        @(posedge clk); #1;
        sop_i = 1'b1; dvalid_i = 1'b0; data_i = 8'hA5; exp_b7 = 1'b0;
      end
    end
  endtask

  task automatic fill(input logic [7:0] seed, input logic [7:0] step);
    for (int i = 0; i < 16; i++) fb[i] = seed + 8'(i) * step;
  endtask

  task automatic check_hold(input string tag);
    @(negedge clk);
    chk(hash_o == last_exp.h, tag, hash_o, last_exp.h);
    chk(bcast_o == last_exp.bc, tag, bcast_o, last_exp.bc);
    chk(mcast_o == last_exp.mc, tag, mcast_o, last_exp.mc);
  endtask

  // Monitor: strobe placement every cycle, scoreboard compare on strobe.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (byte7_o !== exp_b7) begin
        checks++; errors++;
        $display("FAIL R4 strobe actual=%0b expected=%0b", byte7_o, exp_b7);
      end
      if (byte7_o) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected strobe actual=1 expected=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(hash_o == e.h,   "R2 hash at strobe", hash_o, e.h);
          chk(bcast_o == e.bc, "R5 bcast at strobe", bcast_o, e.bc);
          chk(mcast_o == e.mc, "R6 mcast at strobe", mcast_o, e.mc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sop_i = 1'b0; dvalid_i = 1'b0; data_i = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(hash_o == 9'h1FF, "R1 hash reset", hash_o, 9'h1FF);
    chk(bcast_o == 1'b0 && mcast_o == 1'b0, "R1 flags reset", {bcast_o, mcast_o}, 0);
    chk(byte7_o == 1'b0, "R1 strobe reset", byte7_o, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R9: valid bytes with no start give no strobe and no change
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      dvalid_i = 1'b1; data_i = 8'(i); exp_b7 = 1'b0;
    end
    idle(1);
    @(negedge clk);
    chk(hash_o == 9'h1FF, "R9 no start hash", hash_o, 9'h1FF);

    // R2: unicast frame, no gaps
    fill(8'h12, 8'h23); fb[0] = 8'h00;
    send_frame(12, 0); idle(3);
    check_hold("R3 hold after unicast");

    // R5 R7: broadcast with gaps that carry an ignored start strobe
    fill(8'h40, 8'h01);
    for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
    send_frame(10, 2); idle(2);
    check_hold("R7 hold after broadcast");

    // R6: multicast frame
    fill(8'h5E, 8'h11); fb[0] = 8'h01; fb[1] = 8'h00; fb[2] = 8'h5E;
    send_frame(9, 3); idle(2);

    // R5: five all-ones bytes then one not
    for (int i = 0; i < 16; i++) fb[i] = 8'hFF;
    fb[5] = 8'hFE;
    send_frame(8, 0); idle(2);
    check_hold("R5 near broadcast");

    // R8: abort in mid-address, then a fresh frame right away
    fill(8'hC3, 8'h05);
    send_frame(3, 0);
    fill(8'h81, 8'h37);
    send_frame(11, 0); idle(2);
    check_hold("R8 restart mid address");

    // R2: six-byte frame alone: hash checked at the port, no strobe
    fill(8'hA0, 8'h0B);
    send_frame(6, 0); idle(2);
    check_hold("R2 hash six bytes");

    // R8: new start exactly at the seventh position
    fill(8'h77, 8'h13);
    send_frame(6, 0);
    fill(8'h02, 8'h29);
    send_frame(7, 1); idle(3);
    check_hold("R8 start at seventh");

    chk(q.size() == 0, "R4 all strobes seen", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule